// File: doc/BRIEF.md
# Three-Mode Split-Space Page Translator

This block holds the page mapping state for three privilege levels (kernel, supervisor, user) and turns a 16-bit virtual address into a 22-bit physical address. Each privilege level owns two sets of eight page slots. One set maps instruction references and the other maps data references. Every slot is a pair of 16-bit words: a base word that gives the physical location of the page in 64-byte units, and a descriptor word whose access field marks the page as absent, read-only or writable.

A small configuration word holds one data-set enable bit per privilege level, plus the wide-mapping enable and two spare bits. When the enable bit for the current level is clear, data references are mapped through the instruction set. A register port with fixed word addresses in the I/O page reads and writes every slot and the configuration word. Translation is purely combinational. It reports a fault for an absent page, for a write to a read-only page, and for the reserved privilege encoding.

Top module: `paged_mmu`

## Requirements
- R1: After reset, every base word, every descriptor word and the configuration word read as zero, and each of these addresses reports a register hit.
- R2: Slot addresses (octal, byte addresses) are grouped by privilege level. Base words are at kernel 17772340, supervisor 17772240 and user 17777640, plus 020 for the data set, plus 2 times the page. Each descriptor word sits 040 below its base word. An odd address or any other address gives no hit, reads as zero, and a write to it changes nothing.
- R3: The configuration word is at octal 17772516. Bits 5:0 are writable and read back as written: bit 0 enables the data set for user, bit 1 for supervisor, bit 2 for kernel, bit 3 is a stored call-enable flag, bit 4 enables wide mapping, and bit 5 is spare. Bits 15:6 always read as zero.
- R4: Register reads are combinational. A write becomes visible on the clock edge that samples it and not before.
- R5: The privilege input is coded 00 kernel, 01 supervisor and 11 user. The page is va[15:13], and the physical address is (base word × 64) + va[12:0], computed to 22 bits from the slot picked by the privilege level, the space and the page.
- R6: When configuration bit 4 is clear, physical address bits 21:18 are forced to zero. When it is set, all 22 bits are kept.
- R7: An instruction reference (dataRef=0) always uses the instruction set. A data reference uses the data set only when the current level's enable bit is set, and otherwise uses the instruction set.
- R8: Descriptor bits 2:1 control access. 11 allows reads and writes, 01 allows reads and faults on a write, and 00 and 10 fault on any access.
- R9: Privilege code 10 always raises the fault and drives the physical address to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 22 | Register port byte address |
| regWrEn | input | 1 | Register write strobe |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |
| regHit | output | 1 | Address selects an implemented register |
| curMode | input | 2 | Current privilege code |
| dataRef | input | 1 | 1 = data reference, 0 = instruction reference |
| va | input | 16 | Virtual address |
| isWrite | input | 1 | Reference is a write |
| pa | output | 22 | Physical address |
| fault | output | 1 | Translation abort |

## Verification
Directed cases give the instruction and data sets of one page different base words. The bench then flips each level's enable bit, so the resulting address shows which set was chosen, and a wrong enable bit position shows up as a swap. The same translation is repeated with wide mapping off and on, with a base word large enough to reach bits 21:18. Each access code is tried with both a read and a write, which separates read-only handling from absent handling. Seeded random sequences then mix writes to any slot, configuration changes, read-backs and translations under all four privilege codes, and compare each result with a bench model of the tables.

// File: rtl/paged_mmu_pkg.sv
`timescale 1ns/1ps
package paged_mmu_pkg;
  localparam int ADDR_W    = 22;
  localparam int WORD_W    = 16;
  localparam int MODES     = 3;
  localparam int SPACES    = 2;
  localparam int PAGE_BITS = 3;
  localparam int PAGES     = 1 << PAGE_BITS;
  localparam int CFG_W     = 6;
  localparam int MAP22_BIT = 4;

  // Block bases of the per-level slot windows (byte addresses, 64-byte blocks)
  localparam logic [ADDR_W-1:0] KERN_BLK = 22'o17772300;
  localparam logic [ADDR_W-1:0] SUPV_BLK = 22'o17772200;
  localparam logic [ADDR_W-1:0] USER_BLK = 22'o17777600;
  localparam logic [ADDR_W-1:0] CFG_ADDR = 22'o17772516;

  typedef struct packed {
    logic                 regHit;
    logic                 cfgSel;
    logic                 wrStrobe;
    logic [1:0]           regMode;
    logic                 regSpace;
    logic                 regIsBase;
    logic [PAGE_BITS-1:0] regPage;
    logic [1:0]           xMode;
    logic                 xSpace;
    logic                 xIllegal;
  } mmu_strobe_t;
endpackage

// File: rtl/paged_mmu_ctrl.sv
`timescale 1ns/1ps
module paged_mmu_ctrl
  import paged_mmu_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [1:0]        curMode,
  input  logic              dataRef,
  input  logic [2:0]        dspaceEn,
  output mmu_strobe_t       strobe
);
  logic [ADDR_W-7:0] blkAddr;
  logic              useDataSet;

  assign blkAddr = regAddr[ADDR_W-1:6];

  always_comb begin
    strobe = '0;
    useDataSet = 1'b0;
    // register port decode
    if (regAddr == CFG_ADDR) begin
      strobe.regHit = 1'b1;
      strobe.cfgSel = 1'b1;
    end else if (!regAddr[0]) begin
      if (blkAddr == KERN_BLK[ADDR_W-1:6]) begin
        strobe.regHit  = 1'b1;
        strobe.regMode = 2'd0;
      end else if (blkAddr == SUPV_BLK[ADDR_W-1:6]) begin
        strobe.regHit  = 1'b1;
        strobe.regMode = 2'd1;
      end else if (blkAddr == USER_BLK[ADDR_W-1:6]) begin
        strobe.regHit  = 1'b1;
        strobe.regMode = 2'd2;
      end
    end
    strobe.regIsBase = regAddr[5];
    strobe.regSpace  = regAddr[4];
    strobe.regPage   = regAddr[PAGE_BITS:1];
    strobe.wrStrobe  = regWrEn & strobe.regHit;

    // translation select
    case (curMode)
      2'b00: begin strobe.xMode = 2'd0; useDataSet = dspaceEn[2]; end
      2'b01: begin strobe.xMode = 2'd1; useDataSet = dspaceEn[1]; end
      2'b11: begin strobe.xMode = 2'd2; useDataSet = dspaceEn[0]; end
      default: begin strobe.xMode = 2'd0; strobe.xIllegal = 1'b1; end
    endcase
    strobe.xSpace = dataRef & useDataSet;
  end
endmodule

// File: rtl/paged_mmu_dp.sv
`timescale 1ns/1ps
module paged_mmu_dp
  import paged_mmu_pkg::*;
#(
  parameter int VA_W       = 16,
  parameter int PA_W       = 22,
  parameter int SHORT_PA_W = 18,
  parameter int BASE_SHIFT = 6
)(
  input  logic              clk,
  input  logic              rstN,
  input  mmu_strobe_t       strobe,
  input  logic [WORD_W-1:0] regWdata,
  input  logic [VA_W-1:0]   va,
  input  logic              isWrite,
  output logic [WORD_W-1:0] regRdata,
  output logic [CFG_W-1:0]  cfgWord,
  output logic [PA_W-1:0]   pa,
  output logic              fault
);
  localparam int NREG  = MODES * SPACES * PAGES;
  localparam int IDX_W = 2 + 1 + PAGE_BITS;
  localparam int OFFS_W = VA_W - PAGE_BITS;
  localparam logic [PA_W-1:0] SHORT_MASK = PA_W'((64'd1 << SHORT_PA_W) - 64'd1);

  logic [WORD_W-1:0] baseFlat [NREG];
  logic [WORD_W-1:0] descFlat [NREG];
  logic [CFG_W-1:0]  cfgQ;

  // one storage pair per slot
  for (genvar gm = 0; gm < MODES; gm++) begin : gMode
    for (genvar gs = 0; gs < SPACES; gs++) begin : gSpace
      for (genvar gp = 0; gp < PAGES; gp++) begin : gPage
        localparam int IDX = (gm * SPACES + gs) * PAGES + gp;
        logic [WORD_W-1:0] baseQ;
        logic [WORD_W-1:0] descQ;
        logic              slotSel;
        assign slotSel = strobe.wrStrobe && !strobe.cfgSel &&
                         strobe.regMode == 2'(gm) && strobe.regSpace == 1'(gs) &&
                         strobe.regPage == PAGE_BITS'(gp);
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            baseQ <= '0;
            descQ <= '0;
          end else if (slotSel) begin
            if (strobe.regIsBase) baseQ <= regWdata;
            else                  descQ <= regWdata;
          end
        end
        assign baseFlat[IDX] = baseQ;
        assign descFlat[IDX] = descQ;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                cfgQ <= '0;
    else if (strobe.wrStrobe && strobe.cfgSel) cfgQ <= regWdata[CFG_W-1:0];
  end
  assign cfgWord = cfgQ;

  // register read path
  logic [IDX_W-1:0] rdIdx;
  assign rdIdx = {strobe.regMode, strobe.regSpace, strobe.regPage};

  always_comb begin
    regRdata = '0;
    if (strobe.cfgSel)
      regRdata = {{(WORD_W-CFG_W){1'b0}}, cfgQ};
    else if (strobe.regHit)
      regRdata = strobe.regIsBase ? baseFlat[rdIdx] : descFlat[rdIdx];
  end

  // translation path
  logic [IDX_W-1:0]  xIdx;
  logic [WORD_W-1:0] xBase;
  logic [1:0]        xAcc;
  logic [PA_W-1:0]   fullPa;

  assign xIdx   = {strobe.xMode, strobe.xSpace, va[VA_W-1 -: PAGE_BITS]};
  assign xBase  = baseFlat[xIdx];
  assign xAcc   = descFlat[xIdx][2:1];
  assign fullPa = PA_W'({xBase, {BASE_SHIFT{1'b0}}}) + PA_W'(va[OFFS_W-1:0]);

  always_comb begin
    if (strobe.xIllegal)       pa = '0;
    else if (cfgQ[MAP22_BIT])  pa = fullPa;
    else                       pa = fullPa & SHORT_MASK;
    fault = strobe.xIllegal | !xAcc[0] | (!xAcc[1] & isWrite);
  end
endmodule

// File: rtl/paged_mmu.sv
`timescale 1ns/1ps
module paged_mmu
  import paged_mmu_pkg::*;
#(
  parameter int VA_W       = 16,
  parameter int PA_W       = 22,
  parameter int SHORT_PA_W = 18,
  parameter int BASE_SHIFT = 6
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  output logic              regHit,
  input  logic [1:0]        curMode,
  input  logic              dataRef,
  input  logic [VA_W-1:0]   va,
  input  logic              isWrite,
  output logic [PA_W-1:0]   pa,
  output logic              fault
);
  mmu_strobe_t      strobe;
  logic [CFG_W-1:0] cfgWord;

  paged_mmu_ctrl ctrlI (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .curMode (curMode),
    .dataRef (dataRef),
    .dspaceEn(cfgWord[2:0]),
    .strobe  (strobe)
  );

  paged_mmu_dp #(
    .VA_W(VA_W), .PA_W(PA_W), .SHORT_PA_W(SHORT_PA_W), .BASE_SHIFT(BASE_SHIFT)
  ) dpI (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .regWdata(regWdata),
    .va      (va),
    .isWrite (isWrite),
    .regRdata(regRdata),
    .cfgWord (cfgWord),
    .pa      (pa),
    .fault   (fault)
  );

  assign regHit = strobe.regHit;
endmodule

// File: rtl/paged_mmu_chk.sv
`timescale 1ns/1ps
module paged_mmu_chk
  import paged_mmu_pkg::*;
#(
  parameter int VA_W       = 16,
  parameter int PA_W       = 22,
  parameter int SHORT_PA_W = 18,
  parameter int BASE_SHIFT = 6
)(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [WORD_W-1:0] regWdata,
  input logic [WORD_W-1:0] regRdata,
  input logic              regHit,
  input logic [1:0]        curMode,
  input logic [VA_W-1:0]   va,
  input logic [PA_W-1:0]   pa,
  input logic              fault,
  input logic [CFG_W-1:0]  cfgWord
);
  assert_unmapped_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !regHit |-> regRdata == '0);

  assert_cfg_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == CFG_ADDR) |-> (regHit && regRdata[WORD_W-1:CFG_W] == '0));

  assert_write_visible_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWrEn && regHit && regAddr != CFG_ADDR) && $stable(regAddr))
      |-> regRdata == $past(regWdata));

  assert_offset_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (curMode != 2'b10) |-> pa[BASE_SHIFT-1:0] == va[BASE_SHIFT-1:0]);

  assert_short_map_R6: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWord[MAP22_BIT] |-> pa[PA_W-1:SHORT_PA_W] == '0);

  assert_bad_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'b10) |-> (fault && pa == '0));
endmodule

bind paged_mmu paged_mmu_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .SHORT_PA_W(SHORT_PA_W), .BASE_SHIFT(BASE_SHIFT)
) chkI (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWdata(regWdata), .regRdata(regRdata), .regHit(regHit),
  .curMode(curMode), .va(va), .pa(pa), .fault(fault), .cfgWord(cfgWord)
);

// File: tb/paged_mmu_tb_top.sv
`timescale 1ns/1ps
module paged_mmu_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [21:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        regHit;
  logic [1:0]  curMode = 2'b00;
  logic        dataRef = 1'b0;
  logic [15:0] va = '0;
  logic        isWrite = 1'b0;
  logic [21:0] pa;
  logic        fault;

  always #4 clk = ~clk;

  paged_mmu dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWdata(regWdata), .regRdata(regRdata), .regHit(regHit),
    .curMode(curMode), .dataRef(dataRef), .va(va), .isWrite(isWrite),
    .pa(pa), .fault(fault)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit [15:0] shBase [3][2][8];
  bit [15:0] shDesc [3][2][8];
  bit [5:0]  shCfg;

  logic [15:0] rdData;
  logic        rdHit;

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [21:0] slotAddr(int m, int s, bit isBase, int p);
    logic [21:0] blk;
    blk = (m == 0) ? 22'o17772300 : (m == 1) ? 22'o17772200 : 22'o17777600;
    return blk + (isBase ? 22'o40 : 22'o0) + 22'(s * 16) + 22'(p * 2);
  endfunction

  function automatic logic [1:0] modeCode(int m);
    return (m == 0) ? 2'b00 : (m == 1) ? 2'b01 : 2'b11;
  endfunction

  function automatic int pickSpace(int m, bit dref);
    int enBit;
    enBit = (m == 0) ? 2 : (m == 1) ? 1 : 0;
    return (dref && shCfg[enBit]) ? 1 : 0;
  endfunction

  function automatic logic [21:0] expPa(int m, bit dref, logic [15:0] v);
    logic [21:0] full;
    int s;
    s = pickSpace(m, dref);
    full = {shBase[m][s][v[15:13]], 6'b0} + {9'b0, v[12:0]};
    if (!shCfg[4]) full = full & 22'h3FFFF;
    return full;
  endfunction

  function automatic logic expFault(int m, bit dref, logic [15:0] v, bit wr);
    logic [1:0] acc;
    acc = shDesc[m][pickSpace(m, dref)][v[15:13]][2:1];
    return (acc == 2'b00) || (acc == 2'b10) || (acc == 2'b01 && wr);
  endfunction

  task automatic busWrite(input logic [21:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic wrSlot(int m, int s, bit isBase, int p, logic [15:0] d);
    busWrite(slotAddr(m, s, isBase, p), d);
    if (isBase) shBase[m][s][p] = d; else shDesc[m][s][p] = d;
  endtask

  task automatic wrCfg(logic [15:0] d);
    busWrite(22'o17772516, d);
    shCfg = d[5:0];
  endtask

  task automatic busRead(input logic [21:0] a);
    @(negedge clk);
    regAddr = a;
    #2;
    rdData = regRdata; rdHit = regHit;
  endtask

  task automatic xlate(int m, bit dref, logic [15:0] v, bit wr, string req);
    @(negedge clk);
    curMode = modeCode(m); dataRef = dref; va = v; isWrite = wr;
    #2;
    checkEq(req, "pa", 32'(pa), 32'(expPa(m, dref, v)));
    checkEq(req, "fault", 32'(fault), 32'(expFault(m, dref, v, wr)));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of every slot and config word
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 8; p++)
          for (int b = 0; b < 2; b++) begin
            busRead(slotAddr(m, s, b[0], p));
            checkEq("R1", "reset slot", {15'b0, rdHit, rdData}, {15'b0, 1'b1, 16'h0});
          end
    busRead(22'o17772516);
    checkEq("R1", "reset cfg", {15'b0, rdHit, rdData}, {15'b0, 1'b1, 16'h0});

    // R3: config bits 15:6 read zero
    wrCfg(16'hFFFF);
    busRead(22'o17772516);
    checkEq("R3", "cfg readback", 32'(rdData), 32'h003F);
    wrCfg(16'h0000);

    // R2: unmapped and odd addresses, ignored write
    busRead(22'o17772400);
    checkEq("R2", "unmapped", {15'b0, rdHit, rdData}, 32'h0);
    busRead(22'o17772341);
    checkEq("R2", "odd addr", {15'b0, rdHit, rdData}, 32'h0);
    busWrite(22'o17772440, 16'hBEEF);
    busWrite(22'o17772341, 16'hBEEF);
    busRead(slotAddr(0, 0, 1, 0));
    checkEq("R2", "ignored write", 32'(rdData), 32'h0);
    busWrite(22'o17772342, 16'h0777);  // kernel I base page 1
    shBase[0][0][1] = 16'h0777;
    busRead(22'o17772302);             // descriptor 040 lower
    checkEq("R2", "desc of page1", 32'(rdData), 32'h0);
    busRead(22'o17772342);
    checkEq("R2", "base of page1", 32'(rdData), 32'h0777);

    // R4: write not visible before the edge, visible after
    @(negedge clk);
    regAddr = slotAddr(0, 0, 1, 3); regWdata = 16'hF234; regWrEn = 1'b1;
    #2;
    checkEq("R4", "before edge", 32'(regRdata), 32'h0);
    @(negedge clk);
    regWrEn = 1'b0;
    #2;
    checkEq("R4", "after edge", 32'(regRdata), 32'hF234);
    shBase[0][0][3] = 16'hF234;
    wrSlot(0, 0, 0, 3, 16'h0006);

    // R5/R6: short and wide mapping
    xlate(0, 0, 16'h6ABC, 0, "R6 short");
    checkEq("R6", "short hi bits", 32'(pa[21:18]), 32'h0);
    wrCfg(16'h0010);
    xlate(0, 0, 16'h6ABC, 1, "R5 wide");
    checkEq("R5", "wide value", 32'(pa), 32'((22'hF234 << 6) + 22'h0ABC));

    // R7: space selection
    wrSlot(0, 1, 1, 3, 16'h0400);
    wrSlot(0, 1, 0, 3, 16'h0006);
    xlate(0, 1, 16'h6010, 0, "R7 data, kernel set off");
    wrCfg(16'h0014);
    xlate(0, 1, 16'h6010, 0, "R7 data, kernel set on");
    checkEq("R7", "kernel data set", 32'(pa), 32'((22'h0400 << 6) + 22'h0010));
    xlate(0, 0, 16'h6010, 0, "R7 fetch, kernel set on");
    wrCfg(16'h0013);
    xlate(0, 1, 16'h6010, 0, "R7 data, only user/super on");

    // R8: access codes
    wrSlot(2, 0, 1, 5, 16'h0123);
    wrSlot(2, 0, 0, 5, 16'h0002);
    xlate(2, 0, 16'hA004, 0, "R8 ro read");
    checkEq("R8", "ro read", 32'(fault), 32'h0);
    xlate(2, 0, 16'hA004, 1, "R8 ro write");
    checkEq("R8", "ro write", 32'(fault), 32'h1);
    wrSlot(2, 0, 0, 5, 16'h0004);
    xlate(2, 0, 16'hA004, 0, "R8 code10");
    wrSlot(2, 0, 0, 5, 16'h0000);
    xlate(2, 0, 16'hA004, 0, "R8 absent");
    wrSlot(2, 0, 0, 5, 16'hFFF6);
    xlate(2, 0, 16'hA004, 1, "R8 rw write");

    // R9: reserved privilege code
    @(negedge clk);
    curMode = 2'b10; dataRef = 1'b0; va = 16'h6ABC; isWrite = 1'b0;
    #2;
    checkEq("R9", "illegal fault", 32'(fault), 32'h1);
    checkEq("R9", "illegal pa", 32'(pa), 32'h0);

    // random phase: R2 R3 R5 R6 R7 R8
    for (int i = 0; i < 600; i++) begin
      int op, m, s, p;
      op = int'($urandom_range(0, 9));
      m = int'($urandom_range(0, 2));
      s = int'($urandom_range(0, 1));
      p = int'($urandom_range(0, 7));
      if (op < 3) begin
        wrSlot(m, s, 1, p, 16'($urandom));
      end else if (op < 5) begin
        wrSlot(m, s, 0, p, 16'($urandom));
      end else if (op == 5) begin
        wrCfg(16'($urandom));
      end else if (op == 6) begin
        int b;
        b = int'($urandom_range(0, 1));
        busRead(slotAddr(m, s, b[0], p));
        checkEq("R2", "random readback", 32'(rdData),
                32'(b[0] ? shBase[m][s][p] : shDesc[m][s][p]));
      end else begin
        if ($urandom_range(0, 15) == 0) begin
          @(negedge clk);
          curMode = 2'b10; va = 16'($urandom);
          #2;
          checkEq("R9", "random illegal", {31'b0, fault}, 32'h1);
        end else begin
          xlate(m, 1'($urandom), 16'($urandom), 1'($urandom), "R5 R7 R8 random");
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule